// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Status

This block is the receive half of an asynchronous serial port. It samples the serial line on a tick that a divisor input sets, finds each start bit, rebuilds the character bit by bit and puts it in a one-character holding register. Four kinds of receive trouble are caught while it works: a character written over one still unread, a parity mismatch, a missing stop bit and a line held low for a whole frame. Each of these sets its own sticky flag.

A host reads the received character and a status byte over a small read-only register port. A read of the status byte clears every sticky flag. A read of the character marks the holding register empty. One status bit shows the live, inverted level of an active-low terminal-ready input. A level interrupt output stays high while any sticky flag is set and the interrupt enable input is high.

Top module: `uart_rx_status`

## Requirements
- R1: The line is sampled 16 times per bit at a rate of one sample every `baud_div` clocks (0 is treated as 1). The start bit is confirmed at its middle sample, and each of the 8 data bits is taken at its middle, least significant bit first. A completed character can be read at `rd_addr` 0.
- R2: Status bit 0 (overrun) sets when a character completes while the holding register still holds an unread one. The new character replaces the old one.
- R3: With `par_en` high, one parity bit follows the data. Even parity is used when `par_odd` is 0 and odd parity when it is 1. A mismatch sets status bit 1, and the character is still delivered.
- R4: Status bit 2 (frame) sets when the stop bit is sampled as 0. The receiver then waits for the line to go high before it looks for the next start bit.
- R5: A frame that is low at every sample (start, data, parity if enabled, stop) sets status bits 3 (break) and 2 together. It delivers no character, does not set the parity bit, and is reported once for each low period.
- R6: A read with `rd_en` high at `rd_addr` 1 clears status bits 0 to 3 at the next clock edge.
- R7: Status bit 4 always equals the inverse of `dtr_n`. It is not sticky.
- R8: After reset the status byte reads 0xC0 while `dtr_n` is high. Bits 7 and 6 always read 1 and bit 5 always reads 0.
- R9: `irq` is high exactly while `irq_en` is high and at least one of status bits 0 to 3 is set.
- R10: An error event in the same cycle as a status read leaves its flag set after that read.
- R11: A low pulse on the line that ends before the start bit's middle sample is ignored. No character and no flag result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | 16 | Clocks per oversample tick |
| rxd | input | 1 | Serial receive line, idle high |
| dtr_n | input | 1 | Active-low terminal-ready input |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| irq_en | input | 1 | Receive-status interrupt enable |
| rd_en | input | 1 | Read strobe; its side effects take place at the clock edge |
| rd_addr | input | 2 | 0 = character, 1 = status, others read 0 |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Level receive-status interrupt |

## Verification
The assertions assume that `baud_div` and the parity settings stay constant while a frame is in flight, and that a line level lasts long enough to be seen through the two-flop synchroniser. The bench changes the divisor and parity settings only between frames, while the line is idle. It holds every line level for whole bit periods, except for the deliberately short glitch. A reference model in the bench tracks the expected flags and the last character. On every clock it also checks the constant bits, the live terminal-ready bit and the interrupt level against the status byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  // packed: first member is the MSB, so ovr lands on bit 0
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } rx_err_t;

  localparam logic [1:0] ADDR_CHAR = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;

  // index of the middle sample of a half bit, counting from 0
  function automatic int half_mid(input int osr);
    return osr / 2 - 1;
  endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             last;

  assign lim  = (div == '0) ? DIV_W'(1) : div;
  assign last = (cnt >= lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  // R1
  tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != DIV_W'(1) && $stable(div)) |=> !tick)
    else $error("tick_space_chk");

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              par_ev,
  output logic              frm_ev,
  output logic              brk_ev
);
  localparam int CW = $clog2(OSR);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID = CW'(half_mid(OSR));
  localparam logic [CW-1:0] END = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTB = BW'(DATA_W - 1);

  function automatic logic par_expect(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  rx_state_e         state;
  logic [1:0]        sync;
  logic              rx_s;
  logic [CW-1:0]     scnt;
  logic [BW-1:0]     bcnt;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              any_one;
  logic              mid_hit;
  logic              end_hit;
  logic              par_bad;

  assign rx_s    = sync[1];
  assign mid_hit = tick && (scnt == MID);
  assign end_hit = tick && (scnt == END);
  assign par_bad = par_en && (par_bit != par_expect(shreg, par_odd));
  assign rx_byte = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      scnt     <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      any_one  <= 1'b0;
      rx_valid <= 1'b0;
      par_ev   <= 1'b0;
      frm_ev   <= 1'b0;
      brk_ev   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      par_ev   <= 1'b0;
      frm_ev   <= 1'b0;
      brk_ev   <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (tick && !rx_s) begin
            state <= RX_START;
            scnt  <= '0;
          end
        end
        RX_START: begin
          if (mid_hit) begin
            scnt    <= '0;
            bcnt    <= '0;
            any_one <= 1'b0;
            state   <= rx_s ? RX_IDLE : RX_DATA;
          end else if (tick) begin
            scnt <= scnt + CW'(1);
          end
        end
        RX_DATA: begin
          if (end_hit) begin
            scnt    <= '0;
            shreg   <= {rx_s, shreg[DATA_W-1:1]};
            any_one <= any_one | rx_s;
            if (bcnt == LASTB) state <= par_en ? RX_PAR : RX_STOP;
            else               bcnt  <= bcnt + BW'(1);
          end else if (tick) begin
            scnt <= scnt + CW'(1);
          end
        end
        RX_PAR: begin
          if (end_hit) begin
            scnt    <= '0;
            par_bit <= rx_s;
            any_one <= any_one | rx_s;
            state   <= RX_STOP;
          end else if (tick) begin
            scnt <= scnt + CW'(1);
          end
        end
        RX_STOP: begin
          if (end_hit) begin
            scnt <= '0;
            if (rx_s) begin
              rx_valid <= 1'b1;
              par_ev   <= par_bad;
              state    <= RX_IDLE;
            end else begin
              frm_ev <= 1'b1;
              if (!any_one) begin
                brk_ev <= 1'b1;
              end else begin
                rx_valid <= 1'b1;
                par_ev   <= par_bad;
              end
              state <= RX_HOLD;
            end
          end else if (tick) begin
            scnt <= scnt + CW'(1);
          end
        end
        RX_HOLD: begin
          if (rx_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R5
  brk_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ev |-> frm_ev) else $error("brk_frm_chk");

  // R5
  brk_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ev |-> (!rx_valid && !par_ev)) else $error("brk_nodata_chk");

  // R3
  par_with_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_ev |-> (rx_valid && par_en)) else $error("par_with_char_chk");

  // R4
  frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ev |-> (state == RX_HOLD)) else $error("frm_hold_chk");

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              rd_take,
  output logic [DATA_W-1:0] hold,
  output logic              full,
  output logic              ovr_ev
);
  assign ovr_ev = in_valid && full && !rd_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      full <= 1'b0;
    end else begin
      if (in_valid)     full <= 1'b1;
      else if (rd_take) full <= 1'b0;
      if (in_valid) hold <= in_byte;
    end
  end

  // R1
  char_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (full && hold == $past(in_byte))) else $error("char_latch_chk");

  // R2
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_take && !in_valid) |=> full) else $error("ovr_full_chk");

endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rx_err_t    ev,
  input  logic       clr,
  input  logic       irq_en,
  input  logic       dtr_n,
  output logic [7:0] stat_word,
  output logic       irq
);
  rx_err_t sticky;

  always_ff @(posedge clk) begin
    if (!rst_n)   sticky <= '0;
    else if (clr) sticky <= ev;
    else          sticky <= sticky | ev;
  end

  assign stat_word = {2'b11, 1'b0, ~dtr_n, sticky};
  assign irq       = irq_en && (sticky != '0);

  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sticky == $past(ev))) else $error("event_wins_chk");

  // R6
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev == '0) |=> (stat_word[3:0] == 4'h0)) else $error("clr_empty_chk");

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev == '0) |=> !irq) else $error("irq_drop_chk");

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> (irq || !irq_en)) else $error("irq_raise_chk");

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rxd,
  input  logic             dtr_n,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             irq_en,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             irq
);
  logic              tick;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_valid;
  logic              par_ev;
  logic              frm_ev;
  logic              brk_ev;
  logic [DATA_W-1:0] hold;
  logic              full;
  logic              ovr_ev;
  logic              rd_take;
  logic              stat_clr;
  logic [7:0]        stat_word;
  rx_err_t           ev;

  assign rd_take  = rd_en && (rd_addr == ADDR_CHAR);
  assign stat_clr = rd_en && (rd_addr == ADDR_STAT);

  always_comb begin
    ev.ovr = ovr_ev;
    ev.par = par_ev;
    ev.frm = frm_ev;
    ev.brk = brk_ev;
  end

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart_rx_core #(.DATA_W(DATA_W), .OSR(OSR)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd),
    .rx_byte(rx_byte), .rx_valid(rx_valid),
    .par_ev(par_ev), .frm_ev(frm_ev), .brk_ev(brk_ev)
  );

  uart_rx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_byte(rx_byte), .in_valid(rx_valid),
    .rd_take(rd_take), .hold(hold), .full(full), .ovr_ev(ovr_ev)
  );

  uart_rx_stat u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(stat_clr),
    .irq_en(irq_en), .dtr_n(dtr_n), .stat_word(stat_word), .irq(irq)
  );

  generate
    if (DATA_W >= 8) begin : g_wide
      always_comb begin
        unique case (rd_addr)
          ADDR_CHAR: rd_data = hold[7:0];
          ADDR_STAT: rd_data = stat_word;
          default:   rd_data = 8'h00;
        endcase
      end
    end else begin : g_narrow
      always_comb begin
        unique case (rd_addr)
          ADDR_CHAR: rd_data = {{(8-DATA_W){1'b0}}, hold};
          ADDR_STAT: rd_data = stat_word;
          default:   rd_data = 8'h00;
        endcase
      end
    end
  endgenerate

  // R2
  ovr_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ev && !stat_clr) |=> stat_word[0]) else $error("ovr_event_chk");

endmodule

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic        rxd = 1'b1;
  logic        dtr_n = 1'b1;
  logic        par_en = 1'b0;
  logic        par_odd = 1'b0;
  logic        irq_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = 2'd1;
  logic [7:0]  rd_data;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  // reference model state
  logic [3:0] m_err = 4'h0;
  logic [7:0] m_char = 8'h00;
  bit         m_full = 1'b0;

  always #2 clk = ~clk;

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rxd(rxd), .dtr_n(dtr_n),
    .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the port-visible invariants (R7, R8, R9)
  always @(negedge clk) begin
    #1;
    if (mon_on && rst_n && !rd_en && rd_addr == 2'd1) begin
      check(rd_data[7:4] == {3'b110, ~dtr_n}, "R7/R8 live bits",
            int'(rd_data[7:4]), int'({3'b110, ~dtr_n}));
      check(irq == (irq_en && rd_data[3:0] != 4'h0), "R9 irq level",
            int'(irq), int'(irq_en && rd_data[3:0] != 4'h0));
    end
  end

  task automatic line(input logic v, input int bits);
    rxd = v;
    repeat (bits * BIT) @(negedge clk);
  endtask

  function automatic logic ones_odd(input logic [7:0] d);
    int c = 0;
    for (int i = 0; i < 8; i++) if (d[i]) c++;
    return logic'(c % 2);
  endfunction

  task automatic frame(input logic [7:0] d, input bit bad_par, input logic stop);
    line(1'b0, 1);
    for (int i = 0; i < 8; i++) line(d[i], 1);
    if (par_en) line(ones_odd(d) ^ par_odd ^ bad_par, 1);
    line(stop, 1);
    line(1'b1, 2);
    // model: a character arrives
    if (m_full) m_err[0] = 1'b1;
    m_full = 1'b1;
    m_char = d;
    if (par_en && bad_par) m_err[1] = 1'b1;
    if (!stop) m_err[2] = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1;
    rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    rd_addr = 2'd1;
  endtask

  task automatic chk_stat(input string req);
    logic [7:0] d;
    logic [7:0] e;
    e = {3'b110, ~dtr_n, m_err};
    rd(2'd1, d);
    check(d == e, req, int'(d), int'(e));
    m_err = 4'h0;
  endtask

  task automatic chk_char(input string req);
    logic [7:0] d;
    rd(2'd0, d);
    check(d == m_char, req, int'(d), int'(m_char));
    m_full = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R8 reset value
    check(irq == 1'b0, "R8 irq after reset", int'(irq), 0);
    chk_stat("R8 reset status");

    // R7 live terminal-ready bit
    dtr_n = 1'b0;
    chk_stat("R7 dtr low");
    dtr_n = 1'b1;
    chk_stat("R7 dtr high");

    // R1 plain characters
    frame(8'hA5, 1'b0, 1'b1);
    chk_char("R1 char A5");
    chk_stat("R1 clean status");
    frame(8'h3C, 1'b0, 1'b1);
    chk_char("R1 char 3C");

    // R3 even then odd parity
    par_en = 1'b1;
    frame(8'h5A, 1'b0, 1'b1);
    chk_stat("R3 even good");
    chk_char("R3 char 5A");
    frame(8'h07, 1'b1, 1'b1);
    chk_stat("R3 even bad");
    chk_char("R3 char delivered");
    chk_stat("R6 cleared after read");
    par_odd = 1'b1;
    frame(8'h07, 1'b0, 1'b1);
    chk_stat("R3 odd good");
    frame(8'hE1, 1'b1, 1'b1);
    chk_stat("R3 odd bad");
    chk_char("R3 odd char");

    // R5 break with odd parity on: no parity flag, no character
    line(1'b0, 12);
    line(1'b1, 2);
    m_err = m_err | 4'b1100;
    chk_stat("R5 break with parity");
    par_en = 1'b0;
    par_odd = 1'b0;
    line(1'b0, 11);
    line(1'b1, 2);
    m_err = m_err | 4'b1100;
    chk_stat("R5 break");
    chk_char("R5 char unchanged");
    frame(8'h11, 1'b0, 1'b1);
    chk_stat("R5 no overrun after break");
    chk_char("R5 next char");

    // R4 missing stop bit
    frame(8'h81, 1'b0, 1'b0);
    chk_stat("R4 frame error");
    chk_char("R4 char 81");

    // R2 overrun, R9 interrupt gating
    frame(8'h22, 1'b0, 1'b1);
    frame(8'h33, 1'b0, 1'b1);
    #1 check(irq == 1'b0, "R9 irq masked", int'(irq), 0);
    @(negedge clk);
    irq_en = 1'b1;
    #1 check(irq == 1'b1, "R9 irq raised", int'(irq), 1);
    @(negedge clk);
    chk_stat("R2 overrun");
    #1 check(irq == 1'b0, "R9 irq dropped", int'(irq), 0);
    @(negedge clk);
    chk_char("R2 newest char kept");

    // R11 short glitch
    rxd = 1'b0;
    repeat (4 * DIV) @(negedge clk);
    line(1'b1, 3);
    chk_stat("R11 glitch no flag");
    chk_char("R11 glitch no char");

    // R10 event during continuous status reads
    irq_en = 1'b0;
    par_en = 1'b1;
    rd_en = 1'b1;
    rd_addr = 2'd1;
    seen = 0;
    fork
      frame(8'h0F, 1'b1, 1'b1);
      begin
        repeat (13 * BIT) begin
          @(negedge clk);
          #1 if (rd_data[1]) seen++;
        end
      end
    join
    rd_en = 1'b0;
    m_err = 4'h0;
    check(seen == 1, "R10 event beats read", seen, 1);
    chk_stat("R10 cleared next read");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule